// File: doc/BRIEF.md
# Receive Sample Format Packer

This block sits between one receive channel's sample stream and the buffer that carries data toward the host. Each input beat is a pair of 16-bit two's-complement samples, I and Q. A 32-bit per-channel control word tells the block how to reduce each sample: an arithmetic right shift, a kept output width, and whether Q travels with I. The reduced samples are packed into 32-bit words and presented on a valid/ready output.

Only two control settings are legal. One keeps full 16-bit I/Q, with one pair per word. The other keeps the upper byte of each sample, with two pairs per word. A filter-bypass bit in the control word has no effect here. Any other setting is refused: the block flags an error and runs the full-width mode. While a finished word waits to be taken, the block stalls its input.

Top module: `rxfmt_packer`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0 and in_ready is 1.
- R2: With control fields Q-enable bit 9 = 1, width bits [8:4] = 16, shift bits [3:0] = 0 and bits [31:11] all zero, cfg_err is 0. Each accepted pair appears on the clock edge that accepts it, as out_data = {Q[15:0], I[15:0]} with out_valid = 1.
- R3: With bit 9 = 1, width = 8, shift = 8 and bits [31:11] zero, cfg_err is 0. The first accepted pair gives no output. The second completes a word whose bytes, from bit 0 upward, are I0[15:8], Q0[15:8], I1[15:8], Q1[15:8].
- R4: Bit 10 of the control word changes neither cfg_err nor the output of either legal setting.
- R5: Any other control value sets cfg_err to 1, combinationally. This includes bit 9 clear, any other width/shift pair, and any bit in [31:11] set. In that case the block packs as in R2, with no shift.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1, out_data stays stable and in_ready is 0. Input offered during the stall is taken only after the word is accepted.
- R7: A half-filled word held in the byte mode is discarded once the control word selects any other mode for at least one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Per-channel format control word |
| in_valid | input | 1 | Input sample pair offered |
| in_ready | output | 1 | Block can take a sample pair |
| in_i | input | 16 | In-phase sample |
| in_q | input | 16 | Quadrature sample |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed output word |
| cfg_err | output | 1 | Control word is not a legal setting |

## Verification
Two functions can meet on the same edge. The consumer can drain a finished word while the producer holds the next pair on the input. The bench keeps in_valid high with new data through a stall, then raises out_ready for one cycle. It judges that the old word stays intact until it is taken, that in_ready returns only on the cycle after the drain, and that the waiting pair is then packed on the following edge. A second meeting point is a change of control word while a half word is held. The bench switches modes between the two halves and checks that the next byte-mode word contains only pairs sent after the switch back.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  localparam int SMP_W   = 16;            // input sample width
  localparam int WORD_W  = 2 * SMP_W;     // packed output word
  localparam int NAR_W   = SMP_W / 2;     // byte-mode lane width
  localparam int CFG_W   = 32;
  localparam int SH_LSB  = 0;
  localparam int SH_W    = 4;
  localparam int WD_LSB  = 4;
  localparam int WD_W    = 5;
  localparam int QEN_BIT = 9;
  localparam int BYP_BIT = 10;
  localparam int RSV_LSB = 11;

  typedef enum logic [0:0] {
    PK_FULL = 1'b0,
    PK_BYTE = 1'b1
  } pack_mode_e;

  typedef struct packed {
    pack_mode_e       mode;
    logic             bad;
    logic [SH_W-1:0]  sh;
    logic [WD_W-1:0]  wd;
  } fmt_t;

  // arithmetic shift right, then keep the low w bits
  function automatic logic [SMP_W-1:0] scale_sample(
    input logic [SMP_W-1:0] s,
    input logic [SH_W-1:0]  sh,
    input logic [WD_W-1:0]  w
  );
    logic signed [SMP_W-1:0] t;
    logic [SMP_W:0]          m;
    t = $signed(s) >>> sh;
    m = (SMP_W+1)'(1) << w;
    m = m - (SMP_W+1)'(1);
    return t & m[SMP_W-1:0];
  endfunction

  // legal-setting decode; bypass bit masked off before the test
  function automatic fmt_t decode_cfg(input logic [CFG_W-1:0] c);
    fmt_t f;
    logic [CFG_W-1:0] cm;
    logic full_ok, byte_ok;
    cm = c & ~(CFG_W'(1) << BYP_BIT);
    full_ok = (cm[CFG_W-1:RSV_LSB] == '0) && cm[QEN_BIT] &&
              (cm[WD_LSB +: WD_W] == WD_W'(SMP_W)) &&
              (cm[SH_LSB +: SH_W] == SH_W'(0));
    byte_ok = (cm[CFG_W-1:RSV_LSB] == '0) && cm[QEN_BIT] &&
              (cm[WD_LSB +: WD_W] == WD_W'(NAR_W)) &&
              (cm[SH_LSB +: SH_W] == SH_W'(NAR_W));
    f.bad  = !(full_ok || byte_ok);
    f.mode = byte_ok ? PK_BYTE : PK_FULL;
    f.sh   = byte_ok ? SH_W'(NAR_W) : SH_W'(0);
    f.wd   = byte_ok ? WD_W'(NAR_W) : WD_W'(SMP_W);
    return f;
  endfunction
endpackage

// File: rtl/rxfmt_decode.sv
module rxfmt_decode
  import rxfmt_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output fmt_t             fmt
);
  always_comb fmt = decode_cfg(cfg_word);
endmodule

// File: rtl/rxfmt_scale.sv
module rxfmt_scale
  import rxfmt_pkg::*;
(
  input  logic [SMP_W-1:0] smp,
  input  logic [SH_W-1:0]  sh,
  input  logic [WD_W-1:0]  wd,
  output logic [SMP_W-1:0] res
);
  always_comb res = scale_sample(smp, sh, wd);
endmodule

// File: rtl/rxfmt_pack.sv
module rxfmt_pack
  import rxfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pack_mode_e        mode,
  input  logic [SMP_W-1:0]  lane_i,
  input  logic [SMP_W-1:0]  lane_q,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              take,
  output logic              half_pend
);
  logic [SMP_W-1:0] hold;
  logic             byte_sel;

  assign byte_sel = (mode == PK_BYTE);
  assign in_ready = !out_valid;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      half_pend <= 1'b0;
      hold      <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!byte_sel) half_pend <= 1'b0;
      if (take) begin
        if (!byte_sel) begin
          out_data  <= {lane_q, lane_i};
          out_valid <= 1'b1;
        end else if (!half_pend) begin
          hold      <= {lane_q[NAR_W-1:0], lane_i[NAR_W-1:0]};
          half_pend <= 1'b1;
        end else begin
          out_data  <= {lane_q[NAR_W-1:0], lane_i[NAR_W-1:0], hold};
          out_valid <= 1'b1;
          half_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rxfmt_packer.sv
module rxfmt_packer
  import rxfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SMP_W-1:0]  in_i,
  input  logic [SMP_W-1:0]  in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              cfg_err
);
  localparam int LANES = 2;

  fmt_t             fmt;
  logic [SMP_W-1:0] raw  [LANES];
  logic [SMP_W-1:0] lane [LANES];
  logic             take;
  logic             half_pend;
  logic             narrow_sel;

  rxfmt_decode u_dec (.cfg_word(cfg_word), .fmt(fmt));

  assign raw[0]     = in_i;
  assign raw[1]     = in_q;
  assign cfg_err    = fmt.bad;
  assign narrow_sel = (fmt.mode == PK_BYTE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxfmt_scale u_scl (.smp(raw[g]), .sh(fmt.sh), .wd(fmt.wd), .res(lane[g]));
  end

  rxfmt_pack u_pack (
    .clk(clk), .rst_n(rst_n), .mode(fmt.mode),
    .lane_i(lane[0]), .lane_q(lane[1]),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .take(take), .half_pend(half_pend)
  );
endmodule

// File: rtl/rxfmt_packer_chk.sv
module rxfmt_packer_chk
  import rxfmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              cfg_err,
  input logic              narrow_sel,
  input logic              take,
  input logic              half_pend
);
  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
  // R2
  full_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !narrow_sel |=> out_valid);
  // R3
  first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && narrow_sel && !half_pend |=> !out_valid && half_pend);
  // R3
  second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && narrow_sel && half_pend |=> out_valid && !half_pend);
  // R5
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !narrow_sel);
  // R7
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !narrow_sel |=> !half_pend);
endmodule

bind rxfmt_packer rxfmt_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .cfg_err(cfg_err), .narrow_sel(narrow_sel),
  .take(take), .half_pend(half_pend)
);

// File: tb/rxfmt_packer_bench.sv
module rxfmt_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h300;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        cfg_err;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] CFG_FULL = 32'h0000_0300;
  localparam logic [31:0] CFG_BYTE = 32'h0000_0288;
  localparam logic [31:0] CFG_BYP  = 32'h0000_0400;

  always #2 clk = ~clk;

  rxfmt_packer u_rxfmt_packer (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk);
    in_i = i; in_q = q; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [31:0] exp);
    chk(out_valid === 1'b1, req, 32'(out_valid), 32'd1);
    chk(out_data === exp, req, out_data, exp);
    pop();
    chk(out_valid === 1'b0, req, 32'(out_valid), 32'd0);
  endtask

  function automatic logic [31:0] byte_word(input logic [15:0] i0, q0, i1, q1);
    return {q1[15:8], i1[15:8], q0[15:8], i0[15:8]};
  endfunction

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    chk(out_data === 32'd0, "R1 out_data", out_data, 32'd0);
  endtask

  task automatic t_full;
    @(negedge clk); cfg_word = CFG_FULL;
    #1 chk(cfg_err === 1'b0, "R2 cfg_err", 32'(cfg_err), 32'd0);
    push(16'h1234, 16'hABCD);
    expect_word("R2 word", 32'hABCD1234);
    push(16'h8001, 16'h7FFE);
    expect_word("R2 signed word", 32'h7FFE8001);
  endtask

  task automatic t_byte(input logic [31:0] c, input string req);
    @(negedge clk); cfg_word = c;
    #1 chk(cfg_err === 1'b0, req, 32'(cfg_err), 32'd0);
    push(16'h12AB, 16'h34CD);
    chk(out_valid === 1'b0, req, 32'(out_valid), 32'd0);
    push(16'h56EF, 16'h9A01);
    expect_word(req, byte_word(16'h12AB, 16'h34CD, 16'h56EF, 16'h9A01));
  endtask

  task automatic t_bypass;
    t_byte(CFG_BYTE | CFG_BYP, "R4 byte+bypass");
    @(negedge clk); cfg_word = CFG_FULL | CFG_BYP;
    #1 chk(cfg_err === 1'b0, "R4 full+bypass err", 32'(cfg_err), 32'd0);
    push(16'h0F0F, 16'hF0F0);
    expect_word("R4 full+bypass word", 32'hF0F00F0F);
  endtask

  task automatic t_illegal(input logic [31:0] c);
    @(negedge clk); cfg_word = c;
    #1 chk(cfg_err === 1'b1, "R5 cfg_err", 32'(cfg_err), 32'd1);
    push(16'hC3A5, 16'h5A3C);
    expect_word("R5 fallback word", 32'h5A3CC3A5);
  endtask

  task automatic t_stall;
    @(negedge clk); cfg_word = CFG_FULL;
    push(16'h1111, 16'h2222);
    in_i = 16'h3333; in_q = 16'h4444; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === 32'h22221111, "R6 held word",
          out_data, 32'h22221111);
      chk(in_ready === 1'b0, "R6 in_ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R6 drained", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R6 ready back", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_word("R6 waiting pair", 32'h44443333);
  endtask

  task automatic t_discard;
    @(negedge clk); cfg_word = CFG_BYTE;
    push(16'h1100, 16'h2200);
    cfg_word = CFG_FULL;
    @(negedge clk); cfg_word = CFG_BYTE;
    push(16'h3300, 16'h4400);
    chk(out_valid === 1'b0, "R7 half dropped", 32'(out_valid), 32'd0);
    push(16'h5500, 16'h6600);
    expect_word("R7 fresh word", 32'h66554433);
    push(16'h7700, 16'h8800);
    cfg_word = 32'h0000_0088;
    @(negedge clk); cfg_word = CFG_BYTE;
    push(16'h9900, 16'hAA00);
    chk(out_valid === 1'b0, "R7 half dropped illegal", 32'(out_valid), 32'd0);
    push(16'hBB00, 16'hCC00);
    expect_word("R7 fresh word 2", 32'hCCBBAA99);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_full();
    t_byte(CFG_BYTE, "R3 byte word");
    t_bypass();
    t_illegal(32'h0000_0100);
    t_illegal(32'h0000_0280);
    t_illegal(32'h0000_0308);
    t_illegal(32'h0010_0288);
    t_stall();
    t_discard();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule